// File: doc/BRIEF.md
# UART start-frame wake detector

This block watches the receive line of a UART and recognises the beginning of a character: the line leaves its idle-high level and goes low. Each such edge sets a sticky start flag. The flag stays set until software writes a one to its bit position. A control byte holds the start interrupt enable, the flag and a start-frame detection enable. The byte is written and read through a simple register port.

The block combines the control byte with three inputs: the receive-complete flag, the receive-complete interrupt enable and the global interrupt enable. From them it makes two outputs. The interrupt request is a level. The wake request is a single-cycle pulse that goes to a sleeping host. A mode table picks which events may wake the host: the receive-complete event, the start event, or either one. Data reception, baud timing and framing checks are outside this block.

The design is built from three state machines. The line machine has the states `LN_IDLE` and `LN_LOW`. Transition *fall* goes from `LN_IDLE` to `LN_LOW` when the synchronized line reads low. Transition *recover* goes back when the line reads high. The flag machine has the states `FL_CLEAR` and `FL_SET`. Transition *catch* is taken on a fall. Transition *ack* is a write of one at bit 6 with no fall in the same cycle. The wake machine has the states `WK_ARMED`, `WK_PULSE` and `WK_HELD`. Transition *fire* goes from `WK_ARMED` to `WK_PULSE` when the wake condition holds. Transition *hold* goes from `WK_PULSE` to `WK_HELD` while the condition persists. Transition *rearm* returns to `WK_ARMED` from either of those states when the condition drops.

Top module: `sfd_wake`

## Requirements
- R1: After reset the control byte reads 0x00, the interrupt request is low and no wake pulse is present.
- R2: Control byte layout: bit 7 is the start interrupt enable, bit 6 the start flag and bit 5 the detection enable, all read/write. Bits 4:0 always read 0 and writes to them have no effect.
- R3: The receive line passes through a two-flop synchronizer whose flops reset high. If the line is first sampled low at rising edge n after being high, the flag reads 1 after edge n+2 and not before.
- R4: The flag stays set while the line returns high. Writing 0 at bit 6 leaves it unchanged. Writing 1 at bit 6 clears it.
- R5: If a detected fall and a write of 1 at bit 6 land on the same edge, the flag ends set.
- R6: The interrupt request is high exactly when bit 7, the flag and the global interrupt enable are all 1. It follows the global enable combinationally.
- R7: With the detection enable (bit 5) at 0, no wake pulse is produced, whatever the other enables are.
- R8: With detection enabled and both the start interrupt enable and the receive-complete interrupt enable at 0, no wake pulse is produced.
- R9: With detection enabled, the receive-complete path wakes the host when its enable and the receive-complete flag are 1. The start path wakes it when bit 7, the flag and the global enable are 1. When both enables are set, either path wakes it.
- R10: The wake output is a registered one-cycle pulse. It goes high one edge after the wake condition becomes true while the sleep input is high. It does not fire again until the condition has dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Data written to the control byte |
| rd_data | output | 8 | Current control byte |
| rxd | input | 1 | Asynchronous UART receive line |
| rxc_flag | input | 1 | Receive-complete flag from the receiver |
| rxc_ie | input | 1 | Receive-complete interrupt enable |
| gie | input | 1 | Global interrupt enable |
| sleep | input | 1 | Host is asleep |
| irq | output | 1 | Start interrupt request, level |
| wake | output | 1 | Wake pulse for the host |

## Verification
The bench lines up a write that clears the flag with the same edge on which a fall is caught. A design that lets the clear win would lose that start condition and read bit 6 as 0. It counts the edges between the line dropping and the flag appearing. An extra or missing synchronizer stage shifts that count and shows up as a mismatch. It keeps a wake condition true over many cycles, and it drops and raises sleep around a pending condition. A level-style wake, or one that ignores sleep, would then give the wrong pulse count. It also drives the reserved enable combination, the disabled detector, and a start event with the global enable low. Each of these must give zero pulses, and a decoder that treats any of them as a wake source would be caught.

// File: rtl/sfd_wake_pkg.sv
package sfd_wake_pkg;

    localparam int BIT_SIE  = 7;
    localparam int BIT_FLAG = 6;
    localparam int BIT_DET  = 5;

    typedef enum logic {
        LN_IDLE,
        LN_LOW
    } line_state_e;

    typedef enum logic {
        FL_CLEAR,
        FL_SET
    } flag_state_e;

    typedef enum logic [1:0] {
        WK_ARMED,
        WK_PULSE,
        WK_HELD
    } wake_state_e;

    typedef struct packed {
        logic start_ie;
        logic flag;
        logic det_en;
    } ctrl_t;

endpackage

// File: rtl/sfd_sync.sv
module sfd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/sfd_line_fsm.sv
module sfd_line_fsm
    import sfd_wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    output logic fall
);

    line_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LN_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        fall     = 1'b0;
        unique case (state)
            LN_IDLE: if (!line_s) begin
                state_nx = LN_LOW;
                fall     = 1'b1;
            end
            LN_LOW:  if (line_s) state_nx = LN_IDLE;
            default: state_nx = LN_IDLE;
        endcase
    end

    AST_FALL_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);  // R3

endmodule

// File: rtl/sfd_ctrl_reg.sv
module sfd_ctrl_reg
    import sfd_wake_pkg::*;
#(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              fall,
    output ctrl_t             ctrl,
    output logic [CTRL_W-1:0] rd_data
);

    localparam logic [CTRL_W-1:0] KEEP_MASK =
        (CTRL_W'(1) << BIT_SIE) | (CTRL_W'(1) << BIT_FLAG) | (CTRL_W'(1) << BIT_DET);

    flag_state_e fstate, fstate_nx;
    logic        sie_q, det_q;
    logic        ack;

    assign ack = wr_en && wr_data[BIT_FLAG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fstate <= FL_CLEAR;
        else        fstate <= fstate_nx;
    end

    always_comb begin
        fstate_nx = fstate;
        unique case (fstate)
            FL_CLEAR: if (fall)         fstate_nx = FL_SET;
            FL_SET:   if (ack && !fall) fstate_nx = FL_CLEAR;
            default:  fstate_nx = FL_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sie_q <= 1'b0;
            det_q <= 1'b0;
        end else if (wr_en) begin
            sie_q <= wr_data[BIT_SIE];
            det_q <= wr_data[BIT_DET];
        end
    end

    always_comb begin
        ctrl.start_ie = sie_q;
        ctrl.flag     = (fstate == FL_SET);
        ctrl.det_en   = det_q;
        rd_data            = '0;
        rd_data[BIT_SIE]   = ctrl.start_ie;
        rd_data[BIT_FLAG]  = ctrl.flag;
        rd_data[BIT_DET]   = ctrl.det_en;
    end

    logic unused_bits;
    assign unused_bits = ^(wr_data & ~KEEP_MASK);

    AST_FLAG_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> ctrl.flag);  // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.flag && !ack) |=> ctrl.flag);  // R4
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && ack) |=> rd_data[BIT_FLAG]);  // R5
    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~KEEP_MASK) == '0);  // R2

endmodule

// File: rtl/sfd_wake_fsm.sv
module sfd_wake_fsm
    import sfd_wake_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl,
    input  logic  gie,
    input  logic  rxc_ie,
    input  logic  rxc_flag,
    input  logic  sleep,
    output logic  wake
);

    wake_state_e state, state_nx;
    logic        src_hit;
    logic        cond;

    always_comb begin
        src_hit = 1'b0;
        unique case ({ctrl.start_ie, rxc_ie})
            2'b00: src_hit = 1'b0;
            2'b01: src_hit = rxc_flag;
            2'b10: src_hit = ctrl.flag && gie;
            2'b11: src_hit = rxc_flag || (ctrl.flag && gie);
            default: src_hit = 1'b0;
        endcase
        cond = ctrl.det_en && sleep && src_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WK_ARMED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            WK_ARMED: if (cond) state_nx = WK_PULSE;
            WK_PULSE: state_nx = cond ? WK_HELD : WK_ARMED;
            WK_HELD:  if (!cond) state_nx = WK_ARMED;
            default:  state_nx = WK_ARMED;
        endcase
    end

    always_comb begin
        wake = (state == WK_PULSE);
    end

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);  // R10
    AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> $past(sleep));  // R10
    AST_WAKE_NEEDS_DET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> $past(ctrl.det_en));  // R7
    AST_NO_RESERVED_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> $past(ctrl.start_ie || rxc_ie));  // R8

endmodule

// File: rtl/sfd_wake.sv
module sfd_wake
    import sfd_wake_pkg::*;
#(
    parameter int CTRL_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              rxd,
    input  logic              rxc_flag,
    input  logic              rxc_ie,
    input  logic              gie,
    input  logic              sleep,
    output logic              irq,
    output logic              wake
);

    logic  line_s;
    logic  fall;
    ctrl_t ctrl;

    sfd_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (line_s)
    );

    sfd_line_fsm i_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_s (line_s),
        .fall   (fall)
    );

    sfd_ctrl_reg #(.CTRL_W(CTRL_W)) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .fall    (fall),
        .ctrl    (ctrl),
        .rd_data (rd_data)
    );

    sfd_wake_fsm i_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl),
        .gie      (gie),
        .rxc_ie   (rxc_ie),
        .rxc_flag (rxc_flag),
        .sleep    (sleep),
        .wake     (wake)
    );

    assign irq = ctrl.start_ie && ctrl.flag && gie;

    AST_IRQ_DROPS_WITH_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq);  // R6
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rd_data[BIT_FLAG]);  // R6

endmodule

// File: tb/test_sfd_wake.sv
`timescale 1ns/1ps
module test_sfd_wake;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rxd = 1'b1;
    logic       rxc_flag = 1'b0;
    logic       rxc_ie = 1'b0;
    logic       gie = 1'b0;
    logic       sleep = 1'b0;
    logic [7:0] rd_data;
    logic       irq;
    logic       wake;

    int checks = 0;
    int errors = 0;
    int wake_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sfd_wake i_sfd_wake (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .rxd(rxd), .rxc_flag(rxc_flag), .rxc_ie(rxc_ie),
        .gie(gie), .sleep(sleep), .irq(irq), .wake(wake)
    );

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // behavioural reference: line history queue, sticky flag, edge-triggered wake
    bit hist[$] = '{1'b1, 1'b1};
    bit last_s = 1'b1;
    bit m_flag, m_sie, m_det, m_cond_last, m_wake;
    bit s_now, m_fall, m_cond;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist = '{1'b1, 1'b1};
            last_s = 1'b1;
            m_flag = 0; m_sie = 0; m_det = 0; m_cond_last = 0; m_wake = 0;
        end else begin
            s_now  = hist[0];
            m_fall = last_s && !s_now;
            m_cond = m_det && sleep && ((rxc_ie && rxc_flag) || (m_sie && gie && m_flag));
            m_wake = m_cond && !m_cond_last;
            m_cond_last = m_cond;
            if (m_fall) m_flag = 1;
            else if (wr_en && wr_data[6]) m_flag = 0;
            if (wr_en) begin
                m_sie = wr_data[7];
                m_det = wr_data[5];
            end
            last_s = s_now;
            void'(hist.pop_front());
            hist.push_back(rxd);
        end
    end

    always begin
        @(posedge clk);
        #1;
        if (rst_n && !done) begin
            check("R3/R4/R5 readback vs model", rd_data, {m_sie, m_flag, m_det, 5'b0});
            check("R6 irq vs model", {7'b0, irq}, {7'b0, m_sie && gie && m_flag});
            check("R10 wake vs model", {7'b0, wake}, {7'b0, m_wake});
            if (wake) wake_cnt++;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic line_fall();
        @(negedge clk);
        rxd = 1'b0;
        step(3);
        rxd = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(3);
        check("R1 reset readback", rd_data, 8'h00);
        check("R1 reset irq", {7'b0, irq}, 8'h00);
        check("R1 reset wake", {7'b0, wake}, 8'h00);
        rst_n = 1'b1;
        step(2);
        check("R1 readback after release", rd_data, 8'h00);

        wr(8'hFF);
        check("R2 all ones write", rd_data, 8'hA0);
        wr(8'h1F);
        check("R2 low bits ignored", rd_data, 8'h00);

        wr(8'h20);
        @(negedge clk); rxd = 1'b0;
        step(2);
        check("R3 flag not yet set", {7'b0, rd_data[6]}, 8'h00);
        step(1);
        check("R3 flag set", rd_data, 8'h60);
        rxd = 1'b1;
        step(4);
        check("R4 sticky after line high", rd_data, 8'h60);
        wr(8'h20);
        check("R4 write zero keeps flag", rd_data, 8'h60);
        wr(8'h60);
        check("R4 write one clears", rd_data, 8'h20);

        step(2);
        @(negedge clk); rxd = 1'b0;
        step(2);
        wr_en = 1'b1; wr_data = 8'h60;
        @(negedge clk); wr_en = 1'b0;
        check("R5 set wins over clear", rd_data, 8'h60);
        rxd = 1'b1;
        step(3);
        wr(8'h60);

        wr(8'h80);
        gie = 1'b1;
        line_fall();
        step(1);
        check("R6 irq high", {7'b0, irq}, 8'h01);
        @(negedge clk); gie = 1'b0;
        #1;
        check("R6 irq follows gie", {7'b0, irq}, 8'h00);
        wr(8'hC0);

        gie = 1'b1; sleep = 1'b1;
        wr(8'h80);
        wake_cnt = 0;
        line_fall();
        step(4);
        check("R7 detection off no wake", wake_cnt[7:0], 8'd0);
        wr(8'h40);

        wr(8'h20);
        rxc_ie = 1'b0; rxc_flag = 1'b1;
        wake_cnt = 0;
        line_fall();
        step(4);
        check("R8 reserved no wake", wake_cnt[7:0], 8'd0);
        rxc_flag = 1'b0;
        wr(8'h60);

        rxc_ie = 1'b1;
        wake_cnt = 0;
        @(negedge clk); rxc_flag = 1'b1;
        step(3);
        rxc_flag = 1'b0;
        step(2);
        check("R9 receive-complete path", wake_cnt[7:0], 8'd1);

        rxc_ie = 1'b0;
        wr(8'hA0);
        wake_cnt = 0;
        line_fall();
        step(3);
        check("R9 start path", wake_cnt[7:0], 8'd1);

        wr(8'hE0);
        gie = 1'b0;
        wake_cnt = 0;
        line_fall();
        step(3);
        check("R9 start path needs gie", wake_cnt[7:0], 8'd0);

        gie = 1'b1; rxc_ie = 1'b1;
        wr(8'hE0);
        wake_cnt = 0;
        @(negedge clk); rxc_flag = 1'b1;
        step(2);
        rxc_flag = 1'b0;
        step(2);
        line_fall();
        step(3);
        check("R9 both paths", wake_cnt[7:0], 8'd2);

        rxc_ie = 1'b0;
        sleep = 1'b0;
        wr(8'hE0);
        wake_cnt = 0;
        line_fall();
        step(3);
        check("R10 no wake while awake", wake_cnt[7:0], 8'd0);
        sleep = 1'b1;
        step(8);
        check("R10 single pulse on held condition", wake_cnt[7:0], 8'd1);

        done = 1'b1;
        step(1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule